// File: doc/BRIEF.md
# Byte ALU with Status-Flag Update Stage

This block is the arithmetic core of a small 8-bit microcontroller datapath. A combinational unit computes a result from a destination operand, a source operand (or a small immediate) and an operation code. A flag-derivation stage then forms the next carry, zero, negative, overflow, sign and half-carry bits from the operands, the result and the incoming status bits. One register stage captures the result and the next status word whenever the input is marked valid.

The operations are byte add and subtract, with or without the incoming carry, increment, decrement, two's-complement negate, one's complement, arithmetic shift right, loading one bit of the destination from the T flag, and adding a 6-bit immediate to a 16-bit register pair. The register stage has two conditions. In capture, the input is valid and result, high byte and flags are loaded, with `out_valid_o` high in the following cycle. In hold, there is no valid input, the outputs keep their values and `out_valid_o` is low. Reset moves the stage to hold with all outputs zero.

Top module: `alu8_status`

## Requirements
- R1: One cycle after a clock edge with `in_valid_i` high, `out_valid_o` is high and `res_o`, `res_hi_o` and `flags_o` show that operation. After a cycle without valid input, `out_valid_o` is low and the outputs keep their values. Reset clears every output. Flag bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6. Operation codes are ADD=0, ADC=1, SUB=2, SBC=3, INC=4, DEC=5, NEG=6, COM=7, ASR=8, BLD=9, PADD=10.
- R2: ADD and ADC produce (rd+rr+cin) mod 256, with cin equal to incoming C for ADC and 0 for ADD. C is the carry out of bit 7. H is the carry out of bit 3. V is set when the signed sum lies outside -128..127.
- R3: SUB and SBC produce (rd-rr-cin) mod 256, with cin equal to incoming C for SBC and 0 for SUB. C is set when rd < rr+cin. H is set when the low nibble of rd is below the low nibble of rr plus cin. V is set when the signed difference lies outside -128..127.
- R4: ADC and SBC set Z only if the result is zero and incoming Z was set, and otherwise clear it. Every other flag-updating operation sets Z exactly when its result (for PADD, the whole 16-bit result) is zero.
- R5: For every operation except BLD and codes 11-15, N is the top bit of the result (for PADD, of the high byte) and S equals N xor V.
- R6: INC adds 1 and sets V only when rd was 0x7F. DEC subtracts 1 and sets V only when rd was 0x80. Both keep C and H unchanged.
- R7: NEG produces (256-rd) mod 256, so 0x80 stays 0x80. C is set when rd is nonzero, V when rd is 0x80, and H when the low nibble of rd is nonzero.
- R8: COM produces rd xor 0xFF and clears V. C and H are unchanged.
- R9: ASR keeps bit 7 and shifts bits 7..1 down one place. C takes the old bit 0, V is N xor C, and H is unchanged.
- R10: BLD copies incoming T into bit rr[2:0] of rd and keeps the other bits. It leaves all flags unchanged. No operation ever changes T.
- R11: PADD adds `imm_i` to the pair {rr,rd}. The low byte goes to `res_o` and the high byte to `res_hi_o`. C is the carry out of bit 15. V is set when rr bit 7 was 0 and the result bit 15 is 1. H is unchanged.
- R12: For all operations other than PADD, `res_hi_o` is zero. Codes 11-15 return rd on `res_o` and leave all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Operands and code valid this cycle |
| op_i | input | 4 | Operation code |
| rd_i | input | 8 | Destination operand (low byte of pair for PADD) |
| rr_i | input | 8 | Source operand, bit index for BLD, high byte of pair for PADD |
| imm_i | input | 6 | Immediate for PADD |
| flags_i | input | 7 | Current status flags |
| out_valid_o | output | 1 | Registered result valid |
| res_o | output | 8 | Registered result (low byte) |
| res_hi_o | output | 8 | Registered high byte of pair result |
| flags_o | output | 7 | Registered next status flags |

## Verification
The clocked properties compare registered outputs against `$past` of the inputs. They therefore assume the inputs are stable around each capture edge and that `in_valid_i` is held low during reset. The stimulus drives every input on the falling edge and keeps `in_valid_i` low until reset has been released. The sign and T-preservation properties assume that the incoming flag word is arbitrary and need not be self-consistent. For that reason the sweeps vary the incoming C, Z and T bits independently of the operands, so that keep-versus-update behaviour is visible at the ports.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_INC  = 4'd4,
        OP_DEC  = 4'd5,
        OP_NEG  = 4'd6,
        OP_COM  = 4'd7,
        OP_ASR  = 4'd8,
        OP_BLD  = 4'd9,
        OP_PADD = 4'd10
    } alu_op_e;

    localparam int FLW  = 7;
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;
    localparam int FL_T = 6;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    input  logic          sub_i,
    output logic [DW-1:0] res_o,
    output logic          c_o,
    output logic          h_o,
    output logic          v_o
);
    localparam int HB = DW / 2;

    logic [DW:0] wide;
    logic [DW:0] diff_ab;

    always_comb begin
        if (sub_i)
            wide = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, cin_i};
        else
            wide = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
        diff_ab = {1'b0, a_i ^ b_i};
        res_o   = wide[DW-1:0];
        c_o     = wide[DW];
        h_o     = (diff_ab ^ wide) >> HB == '0 ? 1'b0 : ((diff_ab ^ wide) >> HB) & 1;
        if (sub_i)
            v_o = ((wide[DW-1] ^ a_i[DW-1]) & (a_i[DW-1] ^ b_i[DW-1]));
        else
            v_o = ((wide[DW-1] ^ a_i[DW-1]) & ~(a_i[DW-1] ^ b_i[DW-1]));
    end

endmodule

// File: rtl/alu8_unary.sv
module alu8_unary
    import alu8_pkg::*;
#(
    parameter int DW  = 8,
    parameter int BSW = $clog2(DW)
) (
    input  alu_op_e        op_i,
    input  logic [DW-1:0]  rd_i,
    input  logic [BSW-1:0] bitsel_i,
    input  logic           t_i,
    output logic [DW-1:0]  res_o,
    output logic           c_o,
    output logic           v_o
);
    localparam logic [DW-1:0] TOP_ONLY = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] TOP_CLR  = {1'b0, {(DW-1){1'b1}}};

    always_comb begin
        res_o = rd_i;
        c_o   = 1'b0;
        v_o   = 1'b0;
        unique case (op_i)
            OP_INC: begin
                res_o = rd_i + 1'b1;
                v_o   = (res_o == TOP_ONLY);
            end
            OP_DEC: begin
                res_o = rd_i - 1'b1;
                v_o   = (res_o == TOP_CLR);
            end
            OP_COM: begin
                res_o = rd_i ^ {DW{1'b1}};
                v_o   = 1'b0;
            end
            OP_ASR: begin
                res_o = {rd_i[DW-1], rd_i[DW-1:1]};
                c_o   = rd_i[0];
                v_o   = rd_i[DW-1] ^ rd_i[0];
            end
            OP_BLD: begin
                res_o           = rd_i;
                res_o[bitsel_i] = t_i;
            end
            default: begin
                res_o = rd_i;
            end
        endcase
    end

endmodule

// File: rtl/alu8_pair.sv
module alu8_pair #(
    parameter int DW   = 8,
    parameter int IMMW = 6
) (
    input  logic [DW-1:0]   lo_i,
    input  logic [DW-1:0]   hi_i,
    input  logic [IMMW-1:0] imm_i,
    output logic [DW-1:0]   lo_o,
    output logic [DW-1:0]   hi_o,
    output logic            c_o,
    output logic            v_o,
    output logic            z_o
);
    localparam int PW = 2 * DW;

    logic [PW:0] wide;

    always_comb begin
        wide = {1'b0, hi_i, lo_i} + {{(PW + 1 - IMMW){1'b0}}, imm_i};
        lo_o = wide[DW-1:0];
        hi_o = wide[PW-1:DW];
        c_o  = wide[PW];
        v_o  = ~hi_i[DW-1] & wide[PW-1];
        z_o  = (wide[PW-1:0] == '0);
    end

endmodule

// File: rtl/alu8_status.sv
module alu8_status
    import alu8_pkg::*;
#(
    parameter int DW   = 8,
    parameter int IMMW = 6
) (
    input  logic            clk_i,
    input  logic            rst_n_i,
    input  logic            in_valid_i,
    input  logic [3:0]      op_i,
    input  logic [DW-1:0]   rd_i,
    input  logic [DW-1:0]   rr_i,
    input  logic [IMMW-1:0] imm_i,
    input  logic [6:0]      flags_i,
    output logic            out_valid_o,
    output logic [DW-1:0]   res_o,
    output logic [DW-1:0]   res_hi_o,
    output logic [6:0]      flags_o
);
    localparam int BSW = $clog2(DW);

    typedef enum logic {ST_HOLD, ST_CAPTURE} stage_e;

    alu_op_e op;
    stage_e  stage;
    assign op    = alu_op_e'(op_i);
    assign stage = in_valid_i ? ST_CAPTURE : ST_HOLD;

    // adder / subtractor operand steering
    logic [DW-1:0] as_a, as_b, as_res;
    logic          as_cin, as_sub, as_c, as_h, as_v;

    always_comb begin
        as_a   = (op == OP_NEG) ? '0 : rd_i;
        as_b   = (op == OP_NEG) ? rd_i : rr_i;
        as_cin = ((op == OP_ADC) || (op == OP_SBC)) && flags_i[FL_C];
        as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_NEG);
    end

    alu8_addsub #(.DW(DW)) addsub_i (
        .a_i   (as_a),
        .b_i   (as_b),
        .cin_i (as_cin),
        .sub_i (as_sub),
        .res_o (as_res),
        .c_o   (as_c),
        .h_o   (as_h),
        .v_o   (as_v)
    );

    logic [DW-1:0] un_res;
    logic          un_c, un_v;

    alu8_unary #(.DW(DW), .BSW(BSW)) unary_i (
        .op_i     (op),
        .rd_i     (rd_i),
        .bitsel_i (rr_i[BSW-1:0]),
        .t_i      (flags_i[FL_T]),
        .res_o    (un_res),
        .c_o      (un_c),
        .v_o      (un_v)
    );

    logic [DW-1:0] pr_lo, pr_hi;
    logic          pr_c, pr_v, pr_z;

    alu8_pair #(.DW(DW), .IMMW(IMMW)) pair_i (
        .lo_i  (rd_i),
        .hi_i  (rr_i),
        .imm_i (imm_i),
        .lo_o  (pr_lo),
        .hi_o  (pr_hi),
        .c_o   (pr_c),
        .v_o   (pr_v),
        .z_o   (pr_z)
    );

    // flag derivation
    logic [DW-1:0] nx_res, nx_hi;
    logic [6:0]    nx_fl;

    always_comb begin
        nx_res = rd_i;
        nx_hi  = '0;
        nx_fl  = flags_i;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
                nx_res      = as_res;
                nx_fl[FL_C] = as_c;
                nx_fl[FL_H] = as_h;
                nx_fl[FL_V] = as_v;
                nx_fl[FL_N] = as_res[DW-1];
                nx_fl[FL_S] = as_res[DW-1] ^ as_v;
                if ((op == OP_ADC) || (op == OP_SBC))
                    nx_fl[FL_Z] = (as_res == '0) & flags_i[FL_Z];
                else
                    nx_fl[FL_Z] = (as_res == '0);
            end
            OP_INC, OP_DEC, OP_COM, OP_ASR: begin
                nx_res      = un_res;
                nx_fl[FL_V] = un_v;
                nx_fl[FL_N] = un_res[DW-1];
                nx_fl[FL_S] = un_res[DW-1] ^ un_v;
                nx_fl[FL_Z] = (un_res == '0);
                if (op == OP_ASR)
                    nx_fl[FL_C] = un_c;
            end
            OP_BLD: begin
                nx_res = un_res;
            end
            OP_PADD: begin
                nx_res      = pr_lo;
                nx_hi       = pr_hi;
                nx_fl[FL_C] = pr_c;
                nx_fl[FL_V] = pr_v;
                nx_fl[FL_N] = pr_hi[DW-1];
                nx_fl[FL_S] = pr_hi[DW-1] ^ pr_v;
                nx_fl[FL_Z] = pr_z;
            end
            default: begin
                nx_res = rd_i;
            end
        endcase
    end

    // status update stage
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            out_valid_o <= 1'b0;
            res_o       <= '0;
            res_hi_o    <= '0;
            flags_o     <= '0;
        end else begin
            unique case (stage)
                ST_CAPTURE: begin
                    out_valid_o <= 1'b1;
                    res_o       <= nx_res;
                    res_hi_o    <= nx_hi;
                    flags_o     <= nx_fl;
                end
                ST_HOLD: begin
                    out_valid_o <= 1'b0;
                end
                default: begin
                    out_valid_o <= 1'b0;
                end
            endcase
        end
    end

    assert_valid_follow_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        in_valid_i |=> out_valid_o);

    assert_hold_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !in_valid_i |=> (!out_valid_o && $stable(res_o) && $stable(flags_o)));

    assert_sign_rule_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (in_valid_i && (op_i <= 4'd8 || op_i == 4'd10)) |=>
            (flags_o[FL_S] == (flags_o[FL_N] ^ flags_o[FL_V])));

    assert_dec_keeps_c_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (in_valid_i && op_i == 4'd5) |=> (flags_o[FL_C] == $past(flags_i[FL_C])));

    assert_neg_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (in_valid_i && op_i == 4'd6 && rd_i == 8'h80) |=>
            (res_o == 8'h80 && flags_o[FL_V]));

    assert_t_untouched_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        in_valid_i |=> (flags_o[FL_T] == $past(flags_i[FL_T])));

    assert_hi_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (in_valid_i && op_i != 4'd10) |=> (res_hi_o == '0));

endmodule

// File: tb/alu8_status_tb.sv
module alu8_status_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [3:0] op;
    logic [7:0] rd, rr;
    logic [5:0] imm;
    logic [6:0] fl_in;
    logic       out_valid;
    logic [7:0] res, res_hi;
    logic [6:0] fl_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    alu8_status dut_i (
        .clk_i       (clk),
        .rst_n_i     (rst_n),
        .in_valid_i  (in_valid),
        .op_i        (op),
        .rd_i        (rd),
        .rr_i        (rr),
        .imm_i       (imm),
        .flags_i     (fl_in),
        .out_valid_o (out_valid),
        .res_o       (res),
        .res_hi_o    (res_hi),
        .flags_o     (fl_out)
    );

    task automatic check(input int act, input int exp, input string tag, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int sx(input int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    function automatic void model(input int o, input int a, input int b, input int im,
                                  input int f, output int r, output int rh, output int nf);
        int c, s, sv, n, v, idx;
        int fc, fz, fh, ft;
        fc = f & 1; fz = (f >> 1) & 1; fh = (f >> 5) & 1; ft = (f >> 6) & 1;
        r = a; rh = 0; nf = f;
        c = fc; v = (f >> 3) & 1;
        case (o)
            0, 1: begin
                s  = a + b + ((o == 1) ? fc : 0);
                r  = s & 255;
                c  = (s > 255);
                fh = ((a & 15) + (b & 15) + ((o == 1) ? fc : 0)) > 15;
                sv = sx(a) + sx(b) + ((o == 1) ? fc : 0);
                v  = (sv > 127 || sv < -128);
                fz = (o == 1) ? ((r == 0) && fz) : (r == 0);
            end
            2, 3: begin
                s  = (o == 3) ? fc : 0;
                r  = (a - b - s) & 255;
                c  = (a < b + s);
                fh = (a & 15) < ((b & 15) + s);
                sv = sx(a) - sx(b) - s;
                v  = (sv > 127 || sv < -128);
                fz = (o == 3) ? ((r == 0) && fz) : (r == 0);
            end
            4: begin r = (a + 1) & 255; v = (a == 127); fz = (r == 0); end
            5: begin r = (a + 255) & 255; v = (a == 128); fz = (r == 0); end
            6: begin
                r = (256 - a) & 255; c = (a != 0); v = (a == 128);
                fh = ((a & 15) != 0); fz = (r == 0);
            end
            7: begin r = 255 - a; v = 0; fz = (r == 0); end
            8: begin
                r = (a & 128) | (a >> 1); c = a & 1;
                v = ((r >> 7) & 1) ^ c; fz = (r == 0);
            end
            9: begin
                idx = b & 7;
                r = ft ? (a | (1 << idx)) : (a & ~(1 << idx) & 255);
            end
            10: begin
                s  = b * 256 + a + im;
                r  = s & 255;
                rh = (s >> 8) & 255;
                c  = (s > 65535);
                v  = (b < 128) && (rh >= 128);
                fz = ((s & 65535) == 0);
            end
            default: ;
        endcase
        if (o <= 8 || o == 10) begin
            n  = (o == 10) ? ((rh >> 7) & 1) : ((r >> 7) & 1);
            nf = c | (fz << 1) | (n << 2) | (v << 3) | ((n ^ v) << 4) | (fh << 5) | (ft << 6);
        end
    endfunction

    // drive at a falling edge, check at the next one (one register stage)
    task automatic run(input int o, input int a, input int b, input int im, input int f,
                       input string tag);
        int er, eh, ef;
        op = o[3:0]; rd = a[7:0]; rr = b[7:0]; imm = im[5:0]; fl_in = f[6:0];
        in_valid = 1'b1;
        model(o, a, b, im, f, er, eh, ef);
        @(negedge clk);
        check(int'(out_valid), 1, "R1", "out_valid");
        check(int'(res), er, tag, "result");
        check(int'(res_hi), eh, (o == 10) ? "R11" : "R12", "high byte");
        check(int'(fl_out), ef, tag, "flags");
        if (o <= 8 || o == 10)
            check(int'(fl_out[4]), int'(fl_out[2] ^ fl_out[3]), "R5", "sign");
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        int hold_res, hold_fl;
        rst_n = 1'b0; in_valid = 1'b0; op = '0; rd = '0; rr = '0; imm = '0; fl_in = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(int'(out_valid), 0, "R1", "reset valid");
        check(int'(res), 0, "R1", "reset result");
        check(int'(fl_out), 0, "R1", "reset flags");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 and R3 sweeps with varied incoming C and Z (R4)
        for (int o = 0; o < 4; o++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b += 17)
                    run(o, a, b, 0, (a & 1) | (((b >> 4) & 1) << 1) | (((a >> 3) & 1) << 5)
                        | ((b & 1) << 6), (o < 2) ? "R2/R4" : "R3/R4");
        // explicit corners
        run(0, 8'h7F, 8'h01, 0, 0, "R2");
        run(0, 8'hFF, 8'h01, 0, 0, "R2/R4");
        run(1, 8'hFF, 8'h00, 0, 7'h03, "R2/R4");
        run(1, 8'hFF, 8'h00, 0, 7'h01, "R4");
        run(3, 8'h01, 8'h00, 0, 7'h03, "R3/R4");
        run(2, 8'h80, 8'h01, 0, 0, "R3");

        // unary sweeps, two incoming flag patterns
        for (int a = 0; a < 256; a++)
            for (int p = 0; p < 2; p++) begin
                run(4, a, 0, 0, p ? 7'h7F : 7'h00, "R6");
                run(5, a, 0, 0, p ? 7'h21 : 7'h5E, "R6");
                run(6, a, 0, 0, p ? 7'h7F : 7'h00, "R7");
                run(7, a, 0, 0, p ? 7'h29 : 7'h56, "R8");
                run(8, a, 0, 0, p ? 7'h7F : 7'h00, "R9");
            end

        // R10 bit load, every bit index, T both ways
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 8; b++) begin
                run(9, a, b, 0, 7'h40 | (a & 7'h3F), "R10");
                run(9, a, b | 8'hF8, 0, a & 7'h3F, "R10");
            end

        // R11 pair add
        for (int lo = 0; lo < 256; lo += 5)
            for (int hi = 0; hi < 256; hi++)
                run(10, lo, hi, (lo + hi) & 63, (hi & 7'h21) | 7'h40, "R11");
        run(10, 8'hFF, 8'hFF, 1, 0, "R11/R4");
        run(10, 8'hC1, 8'h7F, 63, 0, "R11");
        run(10, 8'h00, 8'h00, 0, 7'h7F, "R11/R4");

        // R12 unused codes
        for (int o = 11; o < 16; o++)
            run(o, 8'hA5 ^ o, 8'h3C, 5, 7'h55 ^ o, "R12");

        // R1 hold: no valid input, outputs stay
        hold_res = int'(res); hold_fl = int'(fl_out);
        in_valid = 1'b0; op = 4'd0; rd = 8'h12; rr = 8'h34; fl_in = 7'h7F;
        @(negedge clk);
        check(int'(out_valid), 0, "R1", "hold valid");
        check(int'(res), hold_res, "R1", "hold result");
        check(int'(fl_out), hold_fl, "R1", "hold flags");
        @(negedge clk);
        check(int'(res), hold_res, "R1", "hold result 2");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule